// File: doc/BRIEF.md
# Video RAM Block Copy Engine

This engine moves data into video RAM in 16-byte blocks on behalf of a processor. Software loads a source address, a destination address and a control byte through a small register port. Writing the control byte starts a transfer in one of two ways. In the immediate way, every block is copied back to back. In the paced way, one block is copied each time the video timing signals the start of a horizontal blanking interval. The engine drives a memory master port with one read address and one write address per cycle. Each cycle moves one beat of several bytes, so a block takes a fixed number of cycles.

The engine applies the register formatting and address rules itself. Both addresses are aligned to a block. The remaining length is clamped so that the destination cannot run past the top of the address space. Before each block, the destination is folded into the 8 KiB video window. A block whose source lies in a region that cannot be read is skipped: nothing is written for it, but the addresses and the count still advance. A paced transfer can be cancelled between blocks. The remaining length can be read back through the control register. A one-cycle pulse to the processor's halt logic marks each skipped block.

Top module: `vram_block_dma`

## Requirements
- R1: The source start is {reg0, reg1} and the destination start is {reg2, reg3}, each with its low 4 bits forced to zero. Reads of registers 0 to 3 return the raw stored bytes. Reads of addresses 5 to 7 return 0xFF.
- R2: Writing register 4 with value v requests (v & 0x7F) + 1 blocks. v[7] = 0 selects the immediate way and v[7] = 1 selects the paced way.
- R3: If destination + 16 × blocks is greater than 0xFFFF, the block count becomes (0x10000 − destination) / 16.
- R4: Block i is written to 0x8000 | ((destination + 16·i) & 0x1FFF) through 0x8000 | ((destination + 16·i) & 0x1FFF) + 15. No write ever falls outside 0x8000 to 0x9FFF.
- R5: Each cycle moves 2 bytes. The read and write addresses share the same offset within the block, and that offset rises by 2 each cycle. In the immediate way, N blocks finish exactly 1 + 8·N cycles after the control write.
- R6: A block whose source start is in 0x8000 to 0x9FFF or in 0xE000 to 0xFFFF writes nothing. It still consumes its 8 cycles, its addresses and its count, and it raises halt_release for one cycle.
- R7: In the paced way, a block runs only after a rising edge of hblank. Each rising edge runs exactly one block, however long hblank stays high.
- R8: Writing register 4 with bit 7 clear while a paced transfer is active stops that transfer. It starts nothing new and leaves the register 4 readback unchanged.
- R9: When the last block completes, bit 7 of register 4 is cleared and the low 7 bits read back 0x7F.
- R10: Register 4 reads back as {stored bit 7, (blocks remaining − 1) & 0x7F}.
- R11: After reset, registers 0 to 3 read 0x00, register 4 reads 0x7F, and mem_wr_en and halt_release are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for both reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hblank | input | 1 | Horizontal blanking level from the video timing |
| mem_rd_addr | output | 16 | Source byte address of the current beat |
| mem_rd_data | input | 16 | Beat data; bits 7:0 are the byte at mem_rd_addr |
| mem_wr_en | output | 1 | Write the current beat |
| mem_wr_addr | output | 16 | Destination byte address of the current beat |
| mem_wr_data | output | 16 | Beat data to write |
| halt_release | output | 1 | One-cycle pulse at the end of each skipped block |

## Verification
The hardest case to reach is a cancellation that lands between two paced blocks. It must leave the readback frozen, produce no further writes and not start an immediate transfer. The bench drives hblank by hand to run exactly one block, issues the cancelling write, and then pulses hblank again to show that nothing moves. A sweep over source regions, destination wrap points and lengths reaches the blocks that cross a region boundary partway through a transfer and the clamped lengths near the top of the address space. The expected bytes, skip pulses and finishing cycle are all computed arithmetically.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
   localparam int ADDR_W = 16;
   localparam int REG_W  = 8;
   localparam int LEN_W  = 7;
   localparam int CNT_W  = LEN_W + 1;

   localparam logic [2:0] RA_SRC_HI = 3'd0;
   localparam logic [2:0] RA_SRC_LO = 3'd1;
   localparam logic [2:0] RA_DST_HI = 3'd2;
   localparam logic [2:0] RA_DST_LO = 3'd3;
   localparam logic [2:0] RA_CTRL   = 3'd4;

   localparam logic [ADDR_W-1:0] VRAM_BASE = 16'h8000;
   localparam logic [ADDR_W-1:0] VRAM_MASK = 16'h1FFF;
   localparam logic [ADDR_W-1:0] XRAM_LO   = 16'hA000;
   localparam logic [ADDR_W-1:0] XRAM_END  = 16'hE000;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ARMED,
      SQ_DELAY,
      SQ_MOVE
   } sq_state_t;

   typedef struct packed {
      logic [ADDR_W-1:0] src;
      logic [ADDR_W-1:0] dst;
      logic [CNT_W-1:0]  count;
      logic              hb_mode;
   } vdma_job_t;
endpackage

// File: rtl/vdma_rise.sv
module vdma_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);
   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;
endmodule

// File: rtl/vdma_regs.sv
module vdma_regs
   import vdma_pkg::*;
#(
   parameter int BLOCK_BYTES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       addr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic [CNT_W-1:0] remain,
   input  logic             hb_active,
   input  logic             done,
   output logic             launch,
   output logic             cancel,
   output vdma_job_t        job
);
   localparam int BLK_SH = $clog2(BLOCK_BYTES);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLOCK_BYTES - 1);
   localparam logic [ADDR_W:0]   ADDR_END   = {1'b1, {ADDR_W{1'b0}}};

   logic [REG_W-1:0] src_hi_q, src_lo_q, dst_hi_q, dst_lo_q, ctrl_q;
   logic             ctrl_wr;
   logic [CNT_W-1:0] req_cnt;
   logic [CNT_W-1:0] remain_m1;
   logic [ADDR_W:0]  span;
   logic [ADDR_W:0]  room;

   assign ctrl_wr = wr_en && (addr == RA_CTRL);
   assign cancel  = ctrl_wr && !wdata[REG_W-1] && hb_active;
   assign launch  = ctrl_wr && !cancel;

   always_comb begin
      job.src     = {src_hi_q, src_lo_q} & ALIGN_MASK;
      job.dst     = {dst_hi_q, dst_lo_q} & ALIGN_MASK;
      job.hb_mode = wdata[REG_W-1];
      req_cnt     = CNT_W'(wdata[LEN_W-1:0]) + CNT_W'(1);
      span        = {1'b0, job.dst} + ((ADDR_W+1)'(req_cnt) << BLK_SH);
      room        = (ADDR_END - {1'b0, job.dst}) >> BLK_SH;
      job.count   = span[ADDR_W] ? room[CNT_W-1:0] : req_cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_hi_q <= '0;
         src_lo_q <= '0;
         dst_hi_q <= '0;
         dst_lo_q <= '0;
         ctrl_q   <= '0;
      end else begin
         if (wr_en && addr == RA_SRC_HI) src_hi_q <= wdata;
         if (wr_en && addr == RA_SRC_LO) src_lo_q <= wdata;
         if (wr_en && addr == RA_DST_HI) dst_hi_q <= wdata;
         if (wr_en && addr == RA_DST_LO) dst_lo_q <= wdata;
         if (launch)    ctrl_q           <= wdata;
         else if (done) ctrl_q[REG_W-1]  <= 1'b0;
      end
   end

   assign remain_m1 = remain - CNT_W'(1);

   always_comb begin
      unique case (addr)
         RA_SRC_HI: rdata = src_hi_q;
         RA_SRC_LO: rdata = src_lo_q;
         RA_DST_HI: rdata = dst_hi_q;
         RA_DST_LO: rdata = dst_lo_q;
         RA_CTRL:   rdata = {ctrl_q[REG_W-1], remain_m1[LEN_W-1:0]};
         default:   rdata = '1;
      endcase
   end
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
   import vdma_pkg::*;
#(
   parameter int BLOCK_BYTES      = 16,
   parameter int CYCLES_PER_BLOCK = 8,
   parameter int START_DELAY      = 1,
   localparam int BEAT_BYTES      = BLOCK_BYTES / CYCLES_PER_BLOCK,
   localparam int DATA_W          = 8 * BEAT_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              cancel,
   input  vdma_job_t         job,
   input  logic              hb_rise,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              halt_release,
   output logic [CNT_W-1:0]  remain,
   output logic              hb_active,
   output logic              done
);
   localparam int BEAT_W  = $clog2(CYCLES_PER_BLOCK);
   localparam int BEAT_SH = $clog2(BEAT_BYTES);
   localparam logic [ADDR_W-1:0] BLK_STEP = ADDR_W'(BLOCK_BYTES);
   localparam sq_state_t START_ST = (START_DELAY > 0) ? SQ_DELAY : SQ_MOVE;

   sq_state_t         st_q;
   logic [ADDR_W-1:0] src_q, dst_q, dst_norm, beat_off;
   logic [CNT_W-1:0]  remain_q;
   logic [BEAT_W-1:0] beat_q;
   logic              hb_q;
   logic              src_ok, last_beat, final_blk, dly_done;

   generate
      if (START_DELAY > 0) begin : g_delay
         localparam int DLY_W = $clog2(START_DELAY + 1);
         logic [DLY_W-1:0] dly_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                                       dly_q <= '0;
            else if (st_q == SQ_DELAY && !launch && !cancel)  dly_q <= dly_q + DLY_W'(1);
            else                                              dly_q <= '0;
         end
         assign dly_done = (dly_q == DLY_W'(START_DELAY - 1));
      end else begin : g_nodelay
         assign dly_done = 1'b1;
      end
   endgenerate

   assign dst_norm  = VRAM_BASE | (dst_q & VRAM_MASK);
   assign src_ok    = (src_q < VRAM_BASE) || (src_q >= XRAM_LO && src_q < XRAM_END);
   assign beat_off  = ADDR_W'(beat_q) << BEAT_SH;
   assign last_beat = (beat_q == BEAT_W'(CYCLES_PER_BLOCK - 1));
   assign final_blk = (remain_q == CNT_W'(1));

   assign mem_rd_addr  = src_q + beat_off;
   assign mem_wr_addr  = dst_norm + beat_off;
   assign mem_wr_en    = (st_q == SQ_MOVE) && src_ok;
   assign mem_wr_data  = mem_rd_data;
   assign halt_release = (st_q == SQ_MOVE) && last_beat && !src_ok;
   assign done         = (st_q == SQ_MOVE) && last_beat && final_blk;
   assign remain       = remain_q;
   assign hb_active    = hb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         src_q    <= '0;
         dst_q    <= '0;
         remain_q <= '0;
         beat_q   <= '0;
         hb_q     <= 1'b0;
      end else if (launch) begin
         st_q     <= job.hb_mode ? SQ_ARMED : START_ST;
         src_q    <= job.src;
         dst_q    <= job.dst;
         remain_q <= job.count;
         beat_q   <= '0;
         hb_q     <= job.hb_mode;
      end else if (cancel) begin
         st_q   <= SQ_IDLE;
         beat_q <= '0;
         hb_q   <= 1'b0;
      end else begin
         unique case (st_q)
            SQ_ARMED: if (hb_rise) st_q <= START_ST;
            SQ_DELAY: if (dly_done) st_q <= SQ_MOVE;
            SQ_MOVE: begin
               if (last_beat) begin
                  beat_q   <= '0;
                  src_q    <= src_q + BLK_STEP;
                  dst_q    <= dst_norm + BLK_STEP;
                  remain_q <= remain_q - CNT_W'(1);
                  if (final_blk) begin
                     st_q <= SQ_IDLE;
                     hb_q <= 1'b0;
                  end else if (hb_q) begin
                     st_q <= SQ_ARMED;
                  end
               end else begin
                  beat_q <= beat_q + BEAT_W'(1);
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma
   import vdma_pkg::*;
#(
   parameter int BLOCK_BYTES      = 16,
   parameter int CYCLES_PER_BLOCK = 8,
   parameter int START_DELAY      = 1,
   localparam int DATA_W          = 8 * (BLOCK_BYTES / CYCLES_PER_BLOCK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              hblank,
   output logic [15:0]       mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_en,
   output logic [15:0]       mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              halt_release
);
   generate
      if ((BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0 || BLOCK_BYTES < 2) begin : g_bad_block
         $error("BLOCK_BYTES must be a power of two");
      end
      if ((CYCLES_PER_BLOCK & (CYCLES_PER_BLOCK - 1)) != 0 || CYCLES_PER_BLOCK < 2
          || CYCLES_PER_BLOCK > BLOCK_BYTES) begin : g_bad_cycles
         $error("CYCLES_PER_BLOCK must be a power of two between 2 and BLOCK_BYTES");
      end
      if (START_DELAY < 0) begin : g_bad_delay
         $error("START_DELAY must not be negative");
      end
      if (ADDR_W != 2 * REG_W) begin : g_bad_addr
         $error("address must be two register bytes wide");
      end
   endgenerate

   logic             launch, cancel, hb_rise, hb_active, done;
   logic [CNT_W-1:0] remain;
   vdma_job_t        job;

   vdma_regs #(.BLOCK_BYTES(BLOCK_BYTES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .remain    (remain),
      .hb_active (hb_active),
      .done      (done),
      .launch    (launch),
      .cancel    (cancel),
      .job       (job)
   );

   vdma_rise u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .level (hblank),
      .rise  (hb_rise)
   );

   vdma_seq #(
      .BLOCK_BYTES      (BLOCK_BYTES),
      .CYCLES_PER_BLOCK (CYCLES_PER_BLOCK),
      .START_DELAY      (START_DELAY)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch       (launch),
      .cancel       (cancel),
      .job          (job),
      .hb_rise      (hb_rise),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_data  (mem_rd_data),
      .mem_wr_en    (mem_wr_en),
      .mem_wr_addr  (mem_wr_addr),
      .mem_wr_data  (mem_wr_data),
      .halt_release (halt_release),
      .remain       (remain),
      .hb_active    (hb_active),
      .done         (done)
   );
endmodule

// File: rtl/vram_block_dma_chk.sv
module vram_block_dma_chk #(
   parameter int BLOCK_BYTES      = 16,
   parameter int CYCLES_PER_BLOCK = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] mem_rd_addr,
   input logic        mem_wr_en,
   input logic [15:0] mem_wr_addr,
   input logic        halt_release
);
   localparam logic [15:0] OFS_MASK = 16'(BLOCK_BYTES - 1);
   localparam logic [15:0] BEAT_B   = 16'(BLOCK_BYTES / CYCLES_PER_BLOCK);

   p_wr_in_vram_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_wr_addr[15:13] == 3'b100));

   p_src_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_rd_addr < 16'h8000 ||
                     (mem_rd_addr >= 16'hA000 && mem_rd_addr < 16'hE000)));

   p_skip_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halt_release |-> !mem_wr_en);

   p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && (mem_wr_addr & OFS_MASK) != 16'd0) |->
         ($past(mem_wr_en) && mem_wr_addr == $past(mem_wr_addr) + BEAT_B));

   p_lockstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ((mem_rd_addr & OFS_MASK) == (mem_wr_addr & OFS_MASK)));
endmodule

bind vram_block_dma vram_block_dma_chk #(
   .BLOCK_BYTES      (BLOCK_BYTES),
   .CYCLES_PER_BLOCK (CYCLES_PER_BLOCK)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mem_rd_addr  (mem_rd_addr),
   .mem_wr_en    (mem_wr_en),
   .mem_wr_addr  (mem_wr_addr),
   .halt_release (halt_release)
);

// File: tb/vram_block_dma_tb.sv
module vram_block_dma_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        hblank = 1'b0;
   logic [15:0] mem_rd_addr, mem_wr_addr;
   logic [15:0] mem_rd_data, mem_wr_data;
   logic        mem_wr_en, halt_release;

   int  n_tests = 0, n_fail = 0;
   int  wr_bytes = 0, halt_cnt = 0;
   bit  finished = 1'b0;
   logic [7:0] vram [int unsigned];

   always #2.5 clk = ~clk;

   vram_block_dma u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank(hblank),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .halt_release(halt_release)
   );

   function automatic logic [7:0] fsrc(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   assign mem_rd_data = {fsrc(mem_rd_addr + 16'd1), fsrc(mem_rd_addr)};

   always @(negedge clk) begin
      if (rst_n && mem_wr_en) begin
         vram[32'(mem_wr_addr)]         = mem_wr_data[7:0];
         vram[32'(mem_wr_addr + 16'd1)] = mem_wr_data[15:8];
         wr_bytes += 2;
      end
      if (rst_n && halt_release) halt_cnt++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_wdata = v; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      reg_addr = a;
      #0.5;
      v = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hb_pulse(input int width);
      @(negedge clk); hblank = 1'b1;
      idle(width);
      hblank = 1'b0;
   endtask

   function automatic bit src_valid(input logic [15:0] s);
      return (s < 16'h8000) || (s >= 16'hA000 && s < 16'hE000);
   endfunction

   // compare written bytes of the first nblk blocks; returns mismatch count
   function automatic int data_bad(input logic [15:0] s0, input logic [15:0] d0, input int nblk);
      int bad = 0;
      for (int i = 0; i < nblk; i++) begin
         logic [15:0] s = s0 + 16'(16 * i);
         logic [15:0] d = 16'h8000 | ((d0 + 16'(16 * i)) & 16'h1FFF);
         if (src_valid(s)) begin
            for (int j = 0; j < 16; j++) begin
               int unsigned a = 32'(d + 16'(j));
               if (!vram.exists(a) || vram[a] != fsrc(s + 16'(j))) bad++;
            end
         end
      end
      return bad;
   endfunction

   task automatic run_gp(input logic [15:0] src, input logic [15:0] dst, input logic [6:0] len);
      int n, k, exp_bytes, exp_halt;
      logic [7:0] v;
      wr(3'd0, src[15:8]);
      wr(3'd1, src[7:0] | 8'h0B);
      wr(3'd2, dst[15:8]);
      wr(3'd3, dst[7:0] | 8'h06);
      vram.delete(); wr_bytes = 0; halt_cnt = 0;
      n = int'(len) + 1;
      if (int'(dst) + 16 * n > 32'hFFFF) n = (32'h10000 - int'(dst)) / 16;
      wr(3'd4, {1'b0, len});
      rd(3'd4, v);
      chk(v == 8'((n - 1) & 8'h7F), "R3/R10 length readback", v, (n - 1) & 8'h7F);
      k = 0;
      while (v != 8'h7F && k < 3000) begin
         @(negedge clk); k++; rd(3'd4, v);
      end
      chk(k == 1 + 8 * n, "R5 finish cycle", k, 1 + 8 * n);
      idle(2);
      exp_bytes = 0; exp_halt = 0;
      for (int i = 0; i < n; i++) begin
         if (src_valid(src + 16'(16 * i))) exp_bytes += 16; else exp_halt++;
      end
      chk(wr_bytes == exp_bytes, "R6 bytes written", wr_bytes, exp_bytes);
      chk(halt_cnt == exp_halt, "R6 skip pulses", halt_cnt, exp_halt);
      k = data_bad(src, dst, n);
      chk(k == 0, "R1/R4 copied data", k, 0);
   endtask

   initial begin
      logic [7:0] v;
      logic [15:0] srcs [10] = '{16'h0000, 16'h4560, 16'h7FF0, 16'h8000, 16'h9000,
                                 16'hA000, 16'hC3A0, 16'hDFE0, 16'hE000, 16'hFF80};
      logic [15:0] dsts [3]  = '{16'h8000, 16'h1230, 16'h9FE0};
      logic [6:0]  lens [3]  = '{7'd0, 7'd5, 7'h1F};

      idle(4);
      // R11 reset state
      chk(mem_wr_en == 1'b0, "R11 no write in reset", mem_wr_en, 0);
      rst_n = 1'b1;
      idle(2);
      for (int a = 0; a < 4; a++) begin
         rd(3'(a), v);
         chk(v == 8'h00, "R11 register reset", v, 0);
      end
      rd(3'd4, v);
      chk(v == 8'h7F, "R11 control reset", v, 8'h7F);
      chk(mem_wr_en == 1'b0 && halt_release == 1'b0, "R11 outputs idle", mem_wr_en, 0);

      // R1 raw readback and unused addresses
      wr(3'd1, 8'h4B);
      rd(3'd1, v);
      chk(v == 8'h4B, "R1 raw readback", v, 8'h4B);
      rd(3'd6, v);
      chk(v == 8'hFF, "R1 unused address", v, 8'hFF);

      // R7 paced mode, one block per rising edge
      wr(3'd0, 8'h10); wr(3'd1, 8'h05); wr(3'd2, 8'h84); wr(3'd3, 8'h09);
      vram.delete(); wr_bytes = 0; halt_cnt = 0;
      wr(3'd4, 8'h83);
      rd(3'd4, v);
      chk(v == 8'h83, "R2/R10 paced readback", v, 8'h83);
      idle(40);
      chk(wr_bytes == 0, "R7 no edge no block", wr_bytes, 0);
      hb_pulse(3); idle(20);
      chk(wr_bytes == 16, "R7 one block per edge", wr_bytes, 16);
      rd(3'd4, v);
      chk(v == 8'h82, "R10 remaining after one", v, 8'h82);
      hb_pulse(40); idle(20);
      chk(wr_bytes == 32, "R7 held level gives one block", wr_bytes, 32);
      hb_pulse(2); idle(20);
      hb_pulse(2); idle(20);
      chk(wr_bytes == 64, "R7 all blocks", wr_bytes, 64);
      rd(3'd4, v);
      chk(v == 8'h7F, "R9 completion readback", v, 8'h7F);
      v = 8'(data_bad(16'h1000, 16'h8400, 4));
      chk(v == 0, "R4 paced data", v, 0);
      hb_pulse(2); idle(20);
      chk(wr_bytes == 64, "R9 idle after last", wr_bytes, 64);

      // R8 cancel between paced blocks
      wr(3'd0, 8'h20); wr(3'd1, 8'h00); wr(3'd2, 8'h08); wr(3'd3, 8'h00);
      vram.delete(); wr_bytes = 0; halt_cnt = 0;
      wr(3'd4, 8'h85);
      hb_pulse(2); idle(20);
      chk(wr_bytes == 16, "R8 first block before cancel", wr_bytes, 16);
      wr(3'd4, 8'h00);
      rd(3'd4, v);
      chk(v == 8'h84, "R8 readback frozen", v, 8'h84);
      idle(30);
      chk(wr_bytes == 16, "R8 cancel starts nothing", wr_bytes, 16);
      hb_pulse(2); idle(15); hb_pulse(2); idle(15);
      chk(wr_bytes == 16, "R8 no blocks after cancel", wr_bytes, 16);
      v = 8'(data_bad(16'h2000, 16'h0800, 1));
      chk(v == 0, "R4 normalised destination", v, 0);

      // immediate-mode sweep (R2 R3 R4 R5 R6)
      foreach (srcs[i]) foreach (dsts[j]) foreach (lens[k])
         run_gp(srcs[i], dsts[j], lens[k]);
      run_gp(16'h0100, 16'hFFC0, 7'h10);   // R3 clamp to 4
      run_gp(16'hA040, 16'hFFF0, 7'h7E);   // R3 clamp to 1

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule